// File: doc/BRIEF.md
# Branch Target Landing-Pad Checker

This block sits at the decode stage of a 64-bit processor pipeline. It decides whether the instruction now being decoded is an acceptable place for an indirect branch to land. The decision uses a 2-bit branch-type register, a flag that says the instruction was fetched from a guarded page, and a strict-mode control bit. When the landing is not acceptable, the block raises a single-cycle trap that carries the current branch type as its syndrome. It also withholds the decode-enable, so the trapping instruction goes no further down the pipeline.

The block also owns the branch-type register. A valid instruction that requests a new branch type loads that type at the next clock edge. An instruction that leaves through an exception, or that traps here, leaves the register unchanged. Every other valid instruction clears the register. Only the first instruction after a typed branch is therefore ever checked.

Top module: `landing_pad_guard`

## Requirements
- R1: The trap is never raised, and `decode_ok` equals `instr_vld`, when the branch type is 0, when `page_guarded` is low, or when `instr_vld` is low.
- R2: An instruction is in the hint space when (instr AND 0xFFFFF01F) equals 0xD503201F, and its selector is instr[11:5]. Selectors 0x19 and 0x1B pass, except when `strict_mode` is 1 and the branch type is 3.
- R3: Hint selector 0x20 fails for every nonzero branch type.
- R4: Hint selector 0x22 fails only for branch type 3, selector 0x24 fails only for branch type 2, and selector 0x26 passes for every branch type.
- R5: An instruction with (instr AND 0xFFE0001F) equal to 0xD4200000 or 0xD4400000 always passes.
- R6: Every other checked instruction fails. A failing instruction drives `trap_pulse` high in the same cycle as `instr_vld`, sets `trap_syndrome` to the current branch type and drives `decode_ok` low. `trap_syndrome` is 0 whenever there is no trap.
- R7: A valid instruction that does not trap, does not request a type and does not exit through an exception clears the branch type at the next edge.
- R8: A valid, non-trapping instruction with `bt_wr_en` high loads `bt_wr_val` into the branch type at the next edge. The load takes priority over the clear.
- R9: A valid, non-trapping instruction with `exc_exit` high and `bt_wr_en` low leaves the branch type unchanged.
- R10: A trapping instruction leaves the branch type unchanged, and its `bt_wr_en` has no effect.
- R11: While `instr_vld` is low, the branch type holds its value.
- R12: When `rst_n` is low at a clock edge (synchronous, active low), the branch type becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_vld | input | 1 | A decoded instruction is present this cycle |
| instr | input | 32 | Instruction word |
| page_guarded | input | 1 | The instruction was fetched from a guarded page |
| strict_mode | input | 1 | Strict control: signing hints do not accept branch type 3 |
| bt_wr_en | input | 1 | The instruction writes a new branch type |
| bt_wr_val | input | 2 | New branch type value |
| exc_exit | input | 1 | The instruction leaves through an exception |
| trap_pulse | output | 1 | Branch-target trap, one cycle, aligned with instr_vld |
| trap_syndrome | output | 2 | Branch type reported with the trap |
| decode_ok | output | 1 | The instruction may be decoded further |
| bt_state | output | 2 | Current branch type |

## Verification
On every cycle, the assertions check that a trap only appears on a valid instruction with a nonzero type on a guarded page, and that it blocks decode and reports the branch type. They also check that the jump-and-call identifier and the two debug encodings never trap, and that each register update follows its rule (clear, load, hold on exception, hold on trap, hold when idle, reset). The compatibility of every other selector against each branch type and each strict-mode setting can only be shown by the bench scenarios. The same holds for the rejection of near-miss encodings and for the way a loaded type arms the check on the next instruction only.

// File: rtl/lpg_pkg.sv
// Package: shared constants and types for the landing-pad checker.
// Assumes 32-bit instruction words and a 2-bit branch type.
package lpg_pkg;
    localparam int INSN_W  = 32;
    localparam int BT_W    = 2;
    localparam int SEL_LSB = 5;
    localparam int SEL_W   = 7;
    localparam int N_DBG   = 2;

    localparam logic [INSN_W-1:0] HINT_MASK  = 32'hFFFF_F01F;
    localparam logic [INSN_W-1:0] HINT_MATCH = 32'hD503_201F;
    localparam logic [INSN_W-1:0] DBG_MASK   = 32'hFFE0_001F;
    localparam logic [N_DBG-1:0][INSN_W-1:0] DBG_MATCH = {32'hD440_0000, 32'hD420_0000};

    localparam logic [SEL_W-1:0] SEL_SIGN_A = 7'h19;
    localparam logic [SEL_W-1:0] SEL_SIGN_B = 7'h1B;
    localparam logic [SEL_W-1:0] SEL_ID     = 7'h20;
    localparam logic [SEL_W-1:0] SEL_ID_C   = 7'h22;
    localparam logic [SEL_W-1:0] SEL_ID_J   = 7'h24;
    localparam logic [SEL_W-1:0] SEL_ID_JC  = 7'h26;

    localparam logic [BT_W-1:0] BT_JUMP = 2'd2;
    localparam logic [BT_W-1:0] BT_CALL = 2'd3;

    typedef enum logic [2:0] {
        LC_OTHER, LC_SIGN, LC_ID_NONE, LC_ID_CALL, LC_ID_JUMP, LC_ID_ANY, LC_DEBUG
    } land_cls_t;
endpackage

// File: rtl/lpg_classify.sv
// Module: lpg_classify
// Sorts an instruction word into one of the landing classes.
// Assumes: the word is stable during the cycle; purely combinational.
module lpg_classify
    import lpg_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output land_cls_t         cls
);
    logic [N_DBG-1:0] dbg_hit;
    logic             in_hint;
    logic [SEL_W-1:0] sel;

    // One comparator per debug encoding.
    for (genvar g = 0; g < N_DBG; g++) begin : g_dbg
        assign dbg_hit[g] = ((insn & DBG_MASK) == DBG_MATCH[g]);
    end

    assign in_hint = ((insn & HINT_MASK) == HINT_MATCH);
    assign sel     = insn[SEL_LSB +: SEL_W];

    // Decode the selector or the debug match into a class.
    always_comb begin
        cls = LC_OTHER;
        if (in_hint) begin
            case (sel)
                SEL_SIGN_A, SEL_SIGN_B: cls = LC_SIGN;
                SEL_ID:                 cls = LC_ID_NONE;
                SEL_ID_C:               cls = LC_ID_CALL;
                SEL_ID_J:               cls = LC_ID_JUMP;
                SEL_ID_JC:              cls = LC_ID_ANY;
                default:                cls = LC_OTHER;
            endcase
        end else if (|dbg_hit) begin
            cls = LC_DEBUG;
        end
    end
endmodule

// File: rtl/lpg_rules.sv
// Module: lpg_rules
// Applies the per-branch-type compatibility rule to a landing class.
// Assumes: bt is nonzero whenever the result is used; combinational.
module lpg_rules
    import lpg_pkg::*;
(
    input  land_cls_t       cls,
    input  logic [BT_W-1:0] bt,
    input  logic            strict,
    output logic            compat
);
    // Compatibility table by class.
    always_comb begin
        case (cls)
            LC_SIGN:    compat = !(strict && (bt == BT_CALL));
            LC_ID_NONE: compat = 1'b0;
            LC_ID_CALL: compat = (bt != BT_CALL);
            LC_ID_JUMP: compat = (bt != BT_JUMP);
            LC_ID_ANY:  compat = 1'b1;
            LC_DEBUG:   compat = 1'b1;
            default:    compat = 1'b0;
        endcase
    end
endmodule

// File: rtl/lpg_btreg.sv
// Module: lpg_btreg
// Holds the branch-type register and its update rules.
// Assumes: trap is only high together with vld; synchronous active-low reset.
module lpg_btreg
    import lpg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            vld,
    input  logic            trap,
    input  logic            wr_en,
    input  logic [BT_W-1:0] wr_val,
    input  logic            exc_exit,
    output logic [BT_W-1:0] bt
);
    // Next-state: reset, hold on trap/exception, load on request, else clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bt <= '0;
        end else if (vld && !trap) begin
            if (wr_en)         bt <= wr_val;
            else if (!exc_exit) bt <= '0;
        end
    end

    AST_BT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && !trap && !wr_en && !exc_exit) |=> (bt == '0));          // R7
    AST_BT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && !trap && wr_en) |=> (bt == $past(wr_val)));             // R8
    AST_BT_EXC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && !trap && !wr_en && exc_exit) |=> $stable(bt));          // R9
    AST_BT_TRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && trap) |=> $stable(bt));                                 // R10
    AST_BT_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !vld |=> $stable(bt));                                          // R11
    AST_BT_RESET: assert property (@(posedge clk)
        !rst_n |=> (bt == '0));                                         // R12
endmodule

// File: rtl/landing_pad_guard.sv
// Module: landing_pad_guard (top)
// Checks each decoded instruction as a landing point for an indirect
// branch and keeps the branch-type register.
// Assumes: instr and controls are valid while instr_vld is high.
module landing_pad_guard
    import lpg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_vld,
    input  logic [INSN_W-1:0] instr,
    input  logic              page_guarded,
    input  logic              strict_mode,
    input  logic              bt_wr_en,
    input  logic [BT_W-1:0]   bt_wr_val,
    input  logic              exc_exit,
    output logic              trap_pulse,
    output logic [BT_W-1:0]   trap_syndrome,
    output logic              decode_ok,
    output logic [BT_W-1:0]   bt_state
);
    land_cls_t       cls;
    logic            compat;
    logic            chk_on;
    logic [BT_W-1:0] bt_q;

    lpg_classify u_cls (
        .insn (instr),
        .cls  (cls)
    );

    lpg_rules u_rules (
        .cls    (cls),
        .bt     (bt_q),
        .strict (strict_mode),
        .compat (compat)
    );

    lpg_btreg u_btreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .vld      (instr_vld),
        .trap     (trap_pulse),
        .wr_en    (bt_wr_en),
        .wr_val   (bt_wr_val),
        .exc_exit (exc_exit),
        .bt       (bt_q)
    );

    // Gate the check and form the trap, syndrome and decode enable.
    always_comb begin
        chk_on        = instr_vld && page_guarded && (bt_q != '0);
        trap_pulse    = chk_on && !compat;
        trap_syndrome = trap_pulse ? bt_q : '0;
        decode_ok     = instr_vld && !trap_pulse;
    end

    assign bt_state = bt_q;

    AST_TRAP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |-> (instr_vld && page_guarded && bt_state != '0));  // R1
    AST_TRAP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |-> (!decode_ok && trap_syndrome == bt_state));      // R6
    AST_SYND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_pulse |-> (trap_syndrome == '0));                         // R6
    AST_JC_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_vld && (instr & HINT_MASK) == HINT_MATCH
         && instr[SEL_LSB +: SEL_W] == SEL_ID_JC) |-> !trap_pulse);     // R4
    AST_DEBUG_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_vld && ((instr & DBG_MASK) == DBG_MATCH[0]
         || (instr & DBG_MASK) == DBG_MATCH[1])) |-> !trap_pulse);      // R5
endmodule

// File: tb/landing_pad_guard_tb.sv
module landing_pad_guard_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_vld = 1'b0;
    logic [31:0] instr = 32'h0;
    logic        page_guarded = 1'b0;
    logic        strict_mode = 1'b0;
    logic        bt_wr_en = 1'b0;
    logic [1:0]  bt_wr_val = 2'd0;
    logic        exc_exit = 1'b0;
    logic        trap_pulse;
    logic [1:0]  trap_syndrome;
    logic        decode_ok;
    logic [1:0]  bt_state;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [1:0] m_bt = 2'd0;

    always #2 clk = ~clk;  // 250 MHz

    landing_pad_guard u_dut (
        .clk(clk), .rst_n(rst_n), .instr_vld(instr_vld), .instr(instr),
        .page_guarded(page_guarded), .strict_mode(strict_mode),
        .bt_wr_en(bt_wr_en), .bt_wr_val(bt_wr_val), .exc_exit(exc_exit),
        .trap_pulse(trap_pulse), .trap_syndrome(trap_syndrome),
        .decode_ok(decode_ok), .bt_state(bt_state)
    );

    // Expected landing verdict from the stated rules.
    function automatic bit exp_pass(input logic [31:0] w, input logic [1:0] bt,
                                    input bit strict, input bit guarded);
        logic [6:0] s;
        if (bt == 2'd0 || !guarded) return 1'b1;
        if ((w & 32'hFFFFF01F) == 32'hD503201F) begin
            s = w[11:5];
            if (s == 7'h19 || s == 7'h1B) return !(strict && bt == 2'd3);
            if (s == 7'h20) return 1'b0;
            if (s == 7'h22) return bt != 2'd3;
            if (s == 7'h24) return bt != 2'd2;
            if (s == 7'h26) return 1'b1;
            return 1'b0;
        end
        if ((w & 32'hFFE0001F) == 32'hD4200000) return 1'b1;
        if ((w & 32'hFFE0001F) == 32'hD4400000) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One instruction: drive at negedge, check outputs, update model at posedge.
    task automatic step(input bit v, input logic [31:0] w, input bit g, input bit st,
                        input bit we, input logic [1:0] wv, input bit ex, input string req);
        bit p, tr;
        @(negedge clk);
        instr_vld = v; instr = w; page_guarded = g; strict_mode = st;
        bt_wr_en = we; bt_wr_val = wv; exc_exit = ex;
        #1;
        p  = exp_pass(w, m_bt, st, g);
        tr = v && !p;
        chk(req, "bt_state", bt_state, m_bt);
        chk(req, "trap_pulse", trap_pulse, tr);
        chk(req, "trap_syndrome", trap_syndrome, tr ? m_bt : 0);
        chk(req, "decode_ok", decode_ok, v && !tr);
        @(posedge clk);
        if (v && !tr) begin
            if (we) m_bt = wv;
            else if (!ex) m_bt = 2'd0;
        end
    endtask

    function automatic logic [31:0] hint(input logic [6:0] s);
        return 32'hD503201F | ({25'd0, s} << 5);
    endfunction

    // Arm a branch type, then present one checked instruction.
    task automatic land(input logic [1:0] bt, input logic [31:0] w, input bit st, input string req);
        step(1, 32'h1234_5678, 1, 0, 1, bt, 0, "R8");
        step(1, w, 1, st, 0, 2'd0, 0, req);
    endtask

    initial begin
        void'($urandom(32'd7321));
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk("R12", "bt_state after reset", bt_state, 0);
        chk("R1", "trap at reset", trap_pulse, 0);
        @(negedge clk); rst_n = 1'b1;

        for (int b = 1; b < 4; b++) begin
            land(b[1:0], hint(7'h19), 1, "R2");
            land(b[1:0], hint(7'h1B), 0, "R2");
            land(b[1:0], hint(7'h1B), 1, "R2");
            land(b[1:0], hint(7'h20), 0, "R3");
            land(b[1:0], hint(7'h22), 0, "R4");
            land(b[1:0], hint(7'h24), 0, "R4");
            land(b[1:0], hint(7'h26), 1, "R4");
            land(b[1:0], 32'hD4200000 | (32'hBEEF << 5), 0, "R5");
            land(b[1:0], 32'hD4400000 | (32'h0042 << 5), 1, "R5");
            land(b[1:0], 32'hD503201E | (32'h26 << 5), 0, "R6");
            land(b[1:0], 32'hD4200001, 0, "R6");
            land(b[1:0], hint(7'h21), 0, "R6");
        end
        // Unguarded page: no check (R1).
        step(1, 32'h0, 1, 0, 1, 2'd3, 0, "R8");
        step(1, 32'hDEAD_BEEF, 0, 1, 0, 2'd0, 0, "R1");
        // Trap holds bt and ignores set-type (R10).
        step(1, 32'h0, 1, 0, 1, 2'd2, 0, "R8");
        step(1, hint(7'h24), 1, 0, 1, 2'd1, 0, "R10");
        step(1, hint(7'h26), 1, 0, 0, 2'd0, 0, "R10");
        // Exception exit holds (R9), idle holds (R11), then clear (R7).
        step(1, 32'h0, 1, 0, 1, 2'd1, 0, "R8");
        step(1, hint(7'h22), 1, 0, 0, 2'd0, 1, "R9");
        step(0, 32'hFFFF_FFFF, 1, 0, 1, 2'd3, 0, "R11");
        step(1, hint(7'h22), 1, 0, 0, 2'd0, 0, "R7");
        step(1, 32'hFFFF_FFFF, 1, 0, 0, 2'd0, 0, "R7");
        // Mid-run reset (R12).
        step(1, 32'h0, 1, 0, 1, 2'd3, 0, "R8");
        @(negedge clk); rst_n = 1'b0; instr_vld = 0;
        @(posedge clk); m_bt = 2'd0;
        @(negedge clk); rst_n = 1'b1; #1;
        chk("R12", "bt_state after mid reset", bt_state, 0);

        for (int i = 0; i < 4000; i++) begin
            logic [31:0] w;
            int k;
            k = $urandom_range(0, 5);
            case (k)
                0: w = hint(7'h18 + 7'($urandom_range(0, 15)));
                1: w = 32'hD4200000 | ($urandom & 32'h001F_FFE0);
                2: w = 32'hD4400000 | ($urandom & 32'h001F_FFE0);
                3: w = hint(7'($urandom)) ^ (32'h1 << $urandom_range(0, 31));
                default: w = $urandom;
            endcase
            step($urandom_range(0, 7) != 0, w, $urandom_range(0, 3) != 0,
                 1'($urandom), $urandom_range(0, 2) == 0, 2'($urandom),
                 $urandom_range(0, 5) == 0, "R6");
        end

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule